// File: doc/BRIEF.md
# Paravirtual Device Register Front End

This block is the port-mapped register file that sits behind the I/O BAR of a legacy paravirtual PCI function. A host bridge hands it single accesses as an offset from the BAR base, a size code, a write flag and write data. Offsets inside the common header are decoded here. Offsets past the header are rebased and passed to a device-specific configuration window, which answers reads in the same cycle. Read data comes back on a registered response one cycle after the request.

The header holds the offered and accepted feature words and a queue selector. Through the selector it reaches, for each queue, a page frame number and, when message-signalled interrupts are active, a vector. It also holds a notify doorbell, the driver status byte, an interrupt cause byte that clears when read, and a vector for configuration-change events. The block drives the legacy INTx level. It resets the device state when the driver writes a zero status or a zero page frame number. It also clears the driver-ready status bit when software turns off bus mastering, except when the driver has already been seen to set that bit with bus mastering off.

Top module: `pv_reg_front`

## Requirements
- R1: A read at offset 0 (host features), 4 (guest features), 8 (selected queue page frame), 12 (queue depth), 14 (queue select), 18 (status, zero-extended) or 19 (interrupt cause, zero-extended) returns that register on `rsp_rdata` with `rsp_valid` one cycle after the request. Any other header offset, including the write-only doorbell at 16, reads as 32'hFFFF_FFFF.
- R2: The header is 20 bytes long while message interrupts are inactive and 24 bytes while they are active. An access at or above that length raises `win_valid` in the request cycle, with `win_addr` equal to the offset minus the length and with size, write flag and data passed through. A window read returns `win_rdata` as the response.
- R3: A pulse on `irq_queue` sets cause bit 0 and a pulse on `irq_config` sets cause bit 1. A read at offset 19 returns the old cause and clears it. A cause pulse that arrives in the same cycle as that read survives the clear.
- R4: `intx` equals cause bit 0 while message interrupts are inactive, and it is low while they are active.
- R5: A nonzero write at offset 8 stores the page frame for the queue that is currently selected. `sel_qaddr` equals the selected queue's page frame shifted left by 12.
- R6: A write at offset 14 changes the selection only when the value is below `NQ`. Otherwise the previous selection is kept.
- R7: A write at offset 18 stores data bits 7:0. If that byte is zero, or if a zero is written at offset 8, the device resets: guest features, status, selection, every page frame and the cause byte go to zero, every vector goes to 16'hFFFF, and `dev_reset` pulses for one cycle after the write.
- R8: A guest-features write with bit 30 set stores the host features ANDed with the fallback mask, or zero when no fallback is configured. Any other value is stored as written.
- R9: While message interrupts are active, offset 20 holds the configuration vector and offset 22 holds the selected queue's vector. A written vector below `NVEC` is stored. Any other value is stored as the sentinel 16'hFFFF. Both vectors reset to the sentinel.
- R10: A command-register write (`cmd_wr`) with `cmd_wmaster` low clears status bit 2 (driver ready). The clear is skipped once a status write with bit 2 set has been seen while `bm_en` was low; only `rst_n` clears that latch.
- R11: A write at offset 16 pulses `notify_valid` for one cycle after the write, with `notify_queue` equal to data bits 15:0.
- R12: `bar_size` is the current header length plus `CFG_LEN`, rounded up to a power of two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| msix_en | input | 1 | Message-signalled interrupts enabled |
| bm_en | input | 1 | Current bus-master enable bit |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wmaster | input | 1 | Bus-master bit of that command write |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code (0 byte, 1 word, 2 dword) |
| req_addr | input | AW | Offset from BAR base |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 32 | Read response data |
| win_valid | output | 1 | Device-config window access |
| win_write | output | 1 | Window write flag |
| win_size | output | 2 | Window access size |
| win_addr | output | AW | Offset inside the window |
| win_wdata | output | 32 | Window write data |
| win_rdata | input | 32 | Window read data, same cycle |
| irq_queue | input | 1 | Queue interrupt event |
| irq_config | input | 1 | Configuration change event |
| intx | output | 1 | Legacy interrupt level |
| notify_valid | output | 1 | Doorbell pulse |
| notify_queue | output | 16 | Doorbell queue index |
| dev_reset | output | 1 | Device reset pulse |
| sel_qaddr | output | 44 | Byte address of selected queue |
| bar_size | output | 32 | Required BAR size in bytes |

## Verification
The assertions assume that `req_valid` requests carry an offset below `bar_size`. They also assume that `msix_en` does not change while a request is outstanding, and that a command-register write is never in the same cycle as a status write. The bench drives one request at a time on the falling edge and changes `msix_en` only between requests. It keeps `cmd_wr` pulses in cycles with no request, and it sweeps offsets only up to the header length plus the window length for the mode under test.

// File: rtl/pv_pkg.sv
package pv_pkg;
   localparam logic [15:0] NO_VEC = 16'hFFFF;
   localparam int HDR_PLAIN = 20;
   localparam int HDR_MSIX  = 24;

   typedef enum logic [3:0] {
      RG_NONE, RG_HOSTF, RG_GUESTF, RG_PFN, RG_QNUM, RG_QSEL,
      RG_NOTIFY, RG_STATUS, RG_ISR, RG_CVEC, RG_QVEC
   } pv_reg_e;

   function automatic logic [31:0] pow2_ceil(input int n);
      logic [31:0] p;
      p = 32'd1;
      for (int i = 0; i < 31; i++) begin
         if (p < n) p = p << 1;
      end
      return p;
   endfunction
endpackage

// File: rtl/pv_hdr_decode.sv
module pv_hdr_decode
   import pv_pkg::*;
#(
   parameter int AW = 8
)(
   input  logic [AW-1:0] addr,
   input  logic          msix_act,
   output logic          in_hdr,
   output pv_reg_e       reg_sel,
   output logic [AW-1:0] win_off
);
   logic [AW-1:0] hdr_len;

   assign hdr_len = msix_act ? AW'(HDR_MSIX) : AW'(HDR_PLAIN);
   assign in_hdr  = addr < hdr_len;
   assign win_off = addr - hdr_len;

   always_comb begin
      reg_sel = RG_NONE;
      if (in_hdr) begin
         case (addr)
            AW'(0):  reg_sel = RG_HOSTF;
            AW'(4):  reg_sel = RG_GUESTF;
            AW'(8):  reg_sel = RG_PFN;
            AW'(12): reg_sel = RG_QNUM;
            AW'(14): reg_sel = RG_QSEL;
            AW'(16): reg_sel = RG_NOTIFY;
            AW'(18): reg_sel = RG_STATUS;
            AW'(19): reg_sel = RG_ISR;
            AW'(20): reg_sel = RG_CVEC;
            AW'(22): reg_sel = RG_QVEC;
            default: reg_sel = RG_NONE;
         endcase
      end
   end
endmodule

// File: rtl/pv_queue_bank.sv
module pv_queue_bank
   import pv_pkg::*;
#(
   parameter int NQ   = 4,
   parameter int NVEC = 3,
   localparam int QW  = (NQ > 1) ? $clog2(NQ) : 1
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic [QW-1:0] sel,
   input  logic          pfn_we,
   input  logic [31:0]   pfn_wd,
   input  logic          vec_we,
   input  logic [15:0]   vec_wd,
   output logic [31:0]   sel_pfn,
   output logic [15:0]   sel_vec
);
   logic [31:0] pfn_q [NQ];
   logic [15:0] vec_q [NQ];

   for (genvar q = 0; q < NQ; q++) begin : g_q
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pfn_q[q] <= '0;
            vec_q[q] <= NO_VEC;
         end else if (clr) begin
            pfn_q[q] <= '0;
            vec_q[q] <= NO_VEC;
         end else if (sel == QW'(q)) begin
            if (pfn_we) pfn_q[q] <= pfn_wd;
            if (vec_we) vec_q[q] <= vec_wd;
         end
      end

      // R9
      vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (vec_q[q] == NO_VEC) || (32'(vec_q[q]) < NVEC));
   end

   assign sel_pfn = pfn_q[sel];
   assign sel_vec = vec_q[sel];
endmodule

// File: rtl/pv_irq.sv
module pv_irq (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       rd_clr,
   input  logic       set_q,
   input  logic       set_c,
   input  logic       msix_act,
   output logic [7:0] isr,
   output logic       intx
);
   logic [7:0] set_bits;

   assign set_bits = {6'b0, set_c, set_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               isr <= '0;
      else if (clr || rd_clr)   isr <= set_bits;
      else                      isr <= isr | set_bits;
   end

   assign intx = !msix_act && isr[0];

   // R3
   isr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && !set_q && !set_c) |=> (isr == 8'h00) && !intx);
   // R3
   isr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_q |=> isr[0]);
endmodule

// File: rtl/pv_reg_front.sv
module pv_reg_front
   import pv_pkg::*;
#(
   parameter int          NQ            = 4,
   parameter int          NVEC          = 3,
   parameter int          QDEPTH        = 256,
   parameter int          CFG_LEN       = 12,
   parameter int          AW            = 8,
   parameter bit          MSIX_PRESENT  = 1'b1,
   parameter logic [31:0] HOST_FEATS    = 32'h4100_003F,
   parameter bit          HAS_FALLBACK  = 1'b1,
   parameter logic [31:0] FALLBACK_MASK = 32'h0000_0F0F,
   parameter int          BAD_FEAT_BIT  = 30,
   parameter int          DRV_OK_BIT    = 2
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          msix_en,
   input  logic          bm_en,
   input  logic          cmd_wr,
   input  logic          cmd_wmaster,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic [1:0]    req_size,
   input  logic [AW-1:0] req_addr,
   input  logic [31:0]   req_wdata,
   output logic          rsp_valid,
   output logic [31:0]   rsp_rdata,
   output logic          win_valid,
   output logic          win_write,
   output logic [1:0]    win_size,
   output logic [AW-1:0] win_addr,
   output logic [31:0]   win_wdata,
   input  logic [31:0]   win_rdata,
   input  logic          irq_queue,
   input  logic          irq_config,
   output logic          intx,
   output logic          notify_valid,
   output logic [15:0]   notify_queue,
   output logic          dev_reset,
   output logic [43:0]   sel_qaddr,
   output logic [31:0]   bar_size
);
   localparam int          QW        = (NQ > 1) ? $clog2(NQ) : 1;
   localparam logic [31:0] BAR_PLAIN = pow2_ceil(HDR_PLAIN + CFG_LEN);
   localparam logic [31:0] BAR_MSIX  = pow2_ceil(HDR_MSIX + CFG_LEN);
   localparam logic [31:0] BAD_VAL   = HAS_FALLBACK ? (HOST_FEATS & FALLBACK_MASK) : 32'h0;

   if (NQ < 1 || NQ > 65535) begin : g_bad_nq
      $error("NQ out of range");
   end
   if (NVEC < 0 || NVEC > 65535) begin : g_bad_nvec
      $error("NVEC out of range");
   end
   if (AW < 6 || (1 << AW) < HDR_MSIX + CFG_LEN) begin : g_bad_aw
      $error("AW too small for header plus window");
   end
   if (BAD_FEAT_BIT > 31 || DRV_OK_BIT > 7) begin : g_bad_bits
      $error("feature or status bit index out of range");
   end

   logic msix_act;
   if (MSIX_PRESENT) begin : g_msix
      assign msix_act = msix_en;
   end else begin : g_nomsix
      assign msix_act = 1'b0;
   end

   logic          in_hdr;
   pv_reg_e       reg_sel;
   logic [AW-1:0] win_off;

   pv_hdr_decode #(.AW(AW)) u_dec (
      .addr(req_addr), .msix_act(msix_act),
      .in_hdr(in_hdr), .reg_sel(reg_sel), .win_off(win_off)
   );

   logic hdr_wr, hdr_rd;
   assign hdr_wr = req_valid && req_write && in_hdr;
   assign hdr_rd = req_valid && !req_write && in_hdr;

   assign win_valid = req_valid && !in_hdr;
   assign win_write = req_write;
   assign win_size  = req_size;
   assign win_addr  = win_off;
   assign win_wdata = req_wdata;

   logic do_reset;
   assign do_reset = hdr_wr &&
      ((reg_sel == RG_PFN && req_wdata == 32'h0) ||
       (reg_sel == RG_STATUS && req_wdata[7:0] == 8'h00));

   logic [15:0] vec_ok;
   assign vec_ok = (32'(req_wdata[15:0]) < NVEC) ? req_wdata[15:0] : NO_VEC;

   logic [31:0]   guest_q;
   logic [QW-1:0] sel_q;
   logic [7:0]    status_q;
   logic [15:0]   cvec_q;
   logic          legacy_q;
   logic [31:0]   sel_pfn;
   logic [15:0]   sel_vec;
   logic [7:0]    isr;

   pv_queue_bank #(.NQ(NQ), .NVEC(NVEC)) u_bank (
      .clk(clk), .rst_n(rst_n), .clr(do_reset), .sel(sel_q),
      .pfn_we(hdr_wr && reg_sel == RG_PFN && !do_reset), .pfn_wd(req_wdata),
      .vec_we(hdr_wr && reg_sel == RG_QVEC), .vec_wd(vec_ok),
      .sel_pfn(sel_pfn), .sel_vec(sel_vec)
   );

   pv_irq u_irq (
      .clk(clk), .rst_n(rst_n), .clr(do_reset),
      .rd_clr(hdr_rd && reg_sel == RG_ISR),
      .set_q(irq_queue), .set_c(irq_config),
      .msix_act(msix_act), .isr(isr), .intx(intx)
   );

   logic [7:0] status_nx;
   always_comb begin
      status_nx = status_q;
      if (hdr_wr && reg_sel == RG_STATUS) status_nx = req_wdata[7:0];
      if (cmd_wr && !cmd_wmaster && !legacy_q) status_nx[DRV_OK_BIT] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         guest_q  <= '0;
         sel_q    <= '0;
         status_q <= '0;
         cvec_q   <= NO_VEC;
         legacy_q <= 1'b0;
      end else begin
         if (do_reset) begin
            guest_q  <= '0;
            sel_q    <= '0;
            status_q <= '0;
            cvec_q   <= NO_VEC;
         end else begin
            status_q <= status_nx;
            if (hdr_wr && reg_sel == RG_GUESTF)
               guest_q <= req_wdata[BAD_FEAT_BIT] ? BAD_VAL : req_wdata;
            if (hdr_wr && reg_sel == RG_QSEL && 32'(req_wdata) < NQ)
               sel_q <= QW'(req_wdata);
            if (hdr_wr && reg_sel == RG_CVEC)
               cvec_q <= vec_ok;
         end
         if (hdr_wr && reg_sel == RG_STATUS && req_wdata[DRV_OK_BIT] && !bm_en)
            legacy_q <= 1'b1;
      end
   end

   logic [31:0] hdr_rdata;
   always_comb begin
      case (reg_sel)
         RG_HOSTF:  hdr_rdata = HOST_FEATS;
         RG_GUESTF: hdr_rdata = guest_q;
         RG_PFN:    hdr_rdata = sel_pfn;
         RG_QNUM:   hdr_rdata = 32'(QDEPTH);
         RG_QSEL:   hdr_rdata = 32'(sel_q);
         RG_STATUS: hdr_rdata = {24'h0, status_q};
         RG_ISR:    hdr_rdata = {24'h0, isr};
         RG_CVEC:   hdr_rdata = {16'h0, cvec_q};
         RG_QVEC:   hdr_rdata = {16'h0, sel_vec};
         default:   hdr_rdata = 32'hFFFF_FFFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_rdata    <= '0;
         notify_valid <= 1'b0;
         notify_queue <= '0;
         dev_reset    <= 1'b0;
      end else begin
         rsp_valid    <= req_valid && !req_write;
         if (req_valid && !req_write)
            rsp_rdata <= in_hdr ? hdr_rdata : win_rdata;
         notify_valid <= hdr_wr && reg_sel == RG_NOTIFY;
         if (hdr_wr && reg_sel == RG_NOTIFY) notify_queue <= req_wdata[15:0];
         dev_reset    <= do_reset;
      end
   end

   assign sel_qaddr = {sel_pfn, 12'h000};
   assign bar_size  = msix_act ? BAR_MSIX : BAR_PLAIN;

   // R6
   qsel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      32'(sel_q) < NQ);
   // R2
   win_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> 32'(req_addr) >= HDR_PLAIN);
   // R7
   zero_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_wr && reg_sel == RG_STATUS && req_wdata[7:0] == 8'h00)
         |=> dev_reset && status_q == 8'h00 && cvec_q == NO_VEC);
   // R10
   bm_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && !cmd_wmaster && !legacy_q && !hdr_wr) |=> !status_q[DRV_OK_BIT]);
   // R11
   notify_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_wr && reg_sel == RG_NOTIFY) |=> notify_valid && notify_queue == $past(req_wdata[15:0]));
endmodule

// File: tb/tb_pv_reg_front.sv
module tb_pv_reg_front;
   localparam int NQ = 4, NVEC = 3, QDEPTH = 256, CFG_LEN = 12, AW = 8;
   localparam logic [31:0] HOSTF = 32'h4100_003F;
   localparam logic [31:0] FBM   = 32'h0000_0F0F;

   logic clk = 0, rst_n = 0;
   logic msix_en = 0, bm_en = 1, cmd_wr = 0, cmd_wmaster = 1;
   logic req_valid = 0, req_write = 0;
   logic [1:0] req_size = 2;
   logic [AW-1:0] req_addr = 0;
   logic [31:0] req_wdata = 0;
   logic rsp_valid, win_valid, win_write, intx, notify_valid, dev_reset;
   logic [31:0] rsp_rdata, win_wdata, win_rdata, bar_size;
   logic [1:0] win_size;
   logic [AW-1:0] win_addr;
   logic [15:0] notify_queue;
   logic [43:0] sel_qaddr;
   logic irq_queue = 0, irq_config = 0;

   assign win_rdata = 32'hA500_0000 | 32'(win_addr);

   always #4 clk = ~clk;

   pv_reg_front #(.NQ(NQ), .NVEC(NVEC), .QDEPTH(QDEPTH), .CFG_LEN(CFG_LEN), .AW(AW),
      .HOST_FEATS(HOSTF), .FALLBACK_MASK(FBM)) dut (.*);

   int checks = 0, errors = 0;
   bit done = 0;

   // bench mirror of programmer-visible state
   logic [31:0] m_guest, m_pfn [NQ];
   logic [15:0] m_qvec [NQ];
   int m_sel;
   logic [7:0] m_status, m_isr;
   logic [15:0] m_cvec;
   logic s_wv, s_ww; logic [AW-1:0] s_wa; logic [31:0] s_wd;

   task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic model_reset();
      m_guest = 0; m_sel = 0; m_status = 0; m_isr = 0; m_cvec = 16'hFFFF;
      for (int q = 0; q < NQ; q++) begin m_pfn[q] = 0; m_qvec[q] = 16'hFFFF; end
   endtask

   task automatic access(bit wr, int a, logic [31:0] d, output logic [31:0] rd);
      @(negedge clk);
      req_valid = 1; req_write = wr; req_addr = AW'(a); req_wdata = d;
      #1;
      s_wv = win_valid; s_ww = win_write; s_wa = win_addr; s_wd = win_wdata;
      @(posedge clk);
      @(negedge clk);
      rd = rsp_rdata;
      req_valid = 0; req_write = 0;
   endtask

   task automatic wr(int a, logic [31:0] d);
      logic [31:0] x;
      access(1, a, d, x);
   endtask

   function automatic logic [31:0] exp_hdr(int off);
      case (off)
         0: return HOSTF;
         4: return m_guest;
         8: return m_pfn[m_sel];
         12: return QDEPTH;
         14: return 32'(m_sel);
         18: return {24'h0, m_status};
         19: return {24'h0, m_isr};
         20: return msix_en ? {16'h0, m_cvec} : 32'hFFFF_FFFF;
         22: return msix_en ? {16'h0, m_qvec[m_sel]} : 32'hFFFF_FFFF;
         default: return 32'hFFFF_FFFF;
      endcase
   endfunction

   task automatic rd_chk(string tag, int a);
      logic [31:0] e, x;
      e = exp_hdr(a);
      access(0, a, 0, x);
      chk(tag, x, e);
      if (a == 19) m_isr = 0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: got hang expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] x;
      int hl;
      model_reset();
      repeat (3) @(negedge clk);
      chk("R1 reset rsp_valid", rsp_valid, 0);
      chk("R4 reset intx", intx, 0);
      rst_n = 1;

      // R1 R2 R9 R12: full header and window sweep in both modes
      for (int mx = 0; mx < 2; mx++) begin
         msix_en = mx[0];
         hl = mx ? 24 : 20;
         @(negedge clk);
         chk("R12 bar size", bar_size, (mx ? 64 : 32));
         for (int a = 0; a < hl; a++) begin
            rd_chk("R1 header read", a);
            chk("R2 no window in header", s_wv, 0);
         end
         for (int a = hl; a < hl + CFG_LEN; a++) begin
            access(0, a, 0, x);
            chk("R2 window valid", s_wv, 1);
            chk("R2 window offset", s_wa, a - hl);
            chk("R2 window read data", x, 32'hA500_0000 | (a - hl));
         end
         access(1, hl + 3, 32'hCAFE_0001, x);
         chk("R2 window write", {s_wv, s_ww, s_wa, s_wd}, {1'b1, 1'b1, 8'd3, 32'hCAFE_0001});
      end

      // R6 select sweep
      for (int v = 0; v < NQ + 3; v++) begin
         wr(14, v);
         if (v < NQ) m_sel = v;
         rd_chk("R6 queue select", 14);
      end

      // R5 page frames per queue
      for (int q = 0; q < NQ; q++) begin
         wr(14, q); m_sel = q;
         wr(8, 32'h0001_2300 + q); m_pfn[q] = 32'h0001_2300 + q;
         chk("R5 queue address", sel_qaddr, {32'h0001_2300 + q, 12'h000});
      end
      for (int q = 0; q < NQ; q++) begin
         wr(14, q); m_sel = q;
         rd_chk("R5 page frame readback", 8);
      end

      // R9 vector sweep (msix active)
      msix_en = 1;
      for (int v = 0; v < 6; v++) begin
         wr(20, v); m_cvec = (v < NVEC) ? 16'(v) : 16'hFFFF;
         rd_chk("R9 config vector", 20);
         wr(22, v + 1); m_qvec[m_sel] = (v + 1 < NVEC) ? 16'(v + 1) : 16'hFFFF;
         rd_chk("R9 queue vector", 22);
      end
      wr(20, 32'h0000_FFFF); m_cvec = 16'hFFFF;
      rd_chk("R9 sentinel write", 20);

      // R8 features
      wr(4, 32'h0000_0123); m_guest = 32'h0000_0123;
      rd_chk("R8 plain features", 4);
      wr(4, 32'h4000_00FF); m_guest = HOSTF & FBM;
      rd_chk("R8 bad-feature fallback", 4);

      // R3 R4 cause byte and INTx
      msix_en = 0;
      @(negedge clk); irq_queue = 1; @(negedge clk); irq_queue = 0; m_isr = 1;
      chk("R4 intx follows cause", intx, 1);
      rd_chk("R3 cause read", 19);
      chk("R4 intx after read", intx, 0);
      @(negedge clk); irq_config = 1; @(negedge clk); irq_config = 0; m_isr = 2;
      chk("R4 config cause no intx", intx, 0);
      @(negedge clk); req_valid = 1; req_addr = 19; irq_queue = 1;
      @(posedge clk); @(negedge clk); req_valid = 0; irq_queue = 0;
      chk("R3 read returns old cause", rsp_rdata, 2);
      m_isr = 1;
      rd_chk("R3 concurrent set survives", 19);
      @(negedge clk); irq_queue = 1; @(negedge clk); irq_queue = 0;
      msix_en = 1; #1;
      chk("R4 intx masked with msix", intx, 0);
      msix_en = 0; #1;
      chk("R4 intx back without msix", intx, 1);
      m_isr = 1; rd_chk("R3 clear", 19);

      // R11 doorbell
      wr(16, 32'h0000_0002);
      chk("R11 notify pulse", {notify_valid, notify_queue}, {1'b1, 16'h0002});
      @(negedge clk);
      chk("R11 notify single cycle", notify_valid, 0);

      // R10 bus-master guard
      bm_en = 1;
      wr(18, 32'h07); m_status = 8'h07;
      @(negedge clk); cmd_wr = 1; cmd_wmaster = 0; @(negedge clk); cmd_wr = 0; cmd_wmaster = 1;
      m_status = 8'h03;
      rd_chk("R10 guard clears driver ready", 18);
      bm_en = 0;
      wr(18, 32'h04); m_status = 8'h04;
      @(negedge clk); cmd_wr = 1; cmd_wmaster = 0; @(negedge clk); cmd_wr = 0; cmd_wmaster = 1;
      rd_chk("R10 legacy latch keeps driver ready", 18);
      bm_en = 1;

      // R7 resets
      msix_en = 1;
      wr(14, 2); m_sel = 2;
      wr(4, 32'h11); wr(22, 1); wr(20, 0);
      wr(18, 32'h100);
      chk("R7 zero status pulse", dev_reset, 1);
      model_reset();
      for (int a = 0; a < 24; a++) rd_chk("R7 state after reset", a);
      for (int q = 0; q < NQ; q++) begin
         wr(14, q); m_sel = q;
         rd_chk("R7 frames cleared", 8);
      end
      wr(8, 32'h55); m_pfn[m_sel] = 32'h55;
      wr(8, 0);
      chk("R7 zero frame pulse", dev_reset, 1);
      model_reset();
      rd_chk("R7 zero frame clears", 8);
      rd_chk("R7 zero frame select", 14);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule